// File: doc/BRIEF.md
# High/Low Count Clock Divider

This block derives a slower clock from an input clock. The output waveform is set by explicit counts rather than by one divide ratio. A high-phase length and a low-phase length are given in input cycles. A half-cycle flag stretches the high phase by half an input period, so odd ratios come out with a duty cycle close to 50%. A bypass flag passes the input clock straight through. The counts arrive as packed configuration words. The configuration in use is replaced only when an output period ends, so software can rewrite the words at any time without producing a short pulse.

A companion packer turns an integer ratio from 1 to 128 into the packed fields. It drives both the two-word layout used for output counters and the single-word layout used for the input-side counter. The divider reads the two-word layout by default. The parameter `IN_LAYOUT` switches the divider to the single-word layout instead.

Top module: `hl_clk_divider`

## Requirements
- R1: With bypass clear, the output is high for `hi` input cycles and then low for `lo` input cycles, and it repeats with a period of `hi + lo` cycles. For an integer ratio N this gives a high time of floor(N/2) cycles.
- R2: In the default layout, `cfg_w1_i` holds the low count in bits 5:0 and the high count in bits 11:6. `cfg_w2_i` holds the bypass flag in bit 6 and the half-cycle flag in bit 7. All other bits are ignored.
- R3: When the half-cycle flag is 1, the output falls half an input cycle after the high count expires. The output therefore stays high for `hi + 0.5` input cycles, while the period is unchanged.
- R4: A high or low count field of zero stands for 64 cycles.
- R5: When the bypass flag is 1, `clk_o` follows `clk_i`, which is a divide ratio of 1.
- R6: The words are sampled only on the input edge that starts a new output period. A change in the middle of a period leaves the rest of that period unchanged.
- R7: While `rst_i` is high on rising edges, `clk_o` is low. The first high phase starts on the first rising edge at which `rst_i` is low.
- R8: The packer registers its outputs, one cycle after `ratio_i`. `pk_w1_o` and `pk_w2_o` use the R2 layout. `pk_in_o` holds low in bits 5:0, high in bits 11:6, bypass in bit 12 and the half-cycle flag in bit 13. All unused bits are zero.
- R9: For N from 2 to 128, the packer emits high = floor(N/2), low = N - high and half = N mod 2, with 64 stored as 0. Read back with R4, high + low equals N. For N = 1 it sets bypass, with high = low = 1 and half = 0.
- R10: The packer treats a `ratio_i` of 0 as 1 and any value above 128 as 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_w1_i | input | WORD_W | Count word: low and high counts |
| cfg_w2_i | input | WORD_W | Flag word: bypass and half-cycle flags |
| clk_o | output | 1 | Divided clock |
| ratio_i | input | RATIO_W | Integer ratio for the packer |
| pk_w1_o | output | WORD_W | Packed count word, R2 layout |
| pk_w2_o | output | WORD_W | Packed flag word, R2 layout |
| pk_in_o | output | WORD_W | Packed single-word input-side layout |

## Verification
A phase position that is wrong or a period end that is missed shows up at `clk_o` within one output period, which is at most 128 input cycles. The bench samples the output once in each half of every input cycle, so a flag that acts half a cycle late or early causes a mismatch in that same cycle. A configuration taken up in the middle of a period changes the remaining high or low length of that period, so the error appears before the next boundary. A wrong field in the packer is visible on the word in the cycle after the ratio is applied.

// File: rtl/hlcd_pkg.sv
package hlcd_pkg;

  // Width of one count field in a configuration word.
  localparam int unsigned FLD_W  = 6;
  // A count field expands to 1..2**FLD_W cycles.
  localparam int unsigned CNT_W  = FLD_W + 1;
  // A full period is up to 2 * 2**FLD_W cycles.
  localparam int unsigned PER_W  = FLD_W + 2;

  // Bit positions shared by every layout. A neighbouring counter tile
  // decodes these positions, so they are fixed.
  localparam int unsigned LO_LSB       = 0;
  localparam int unsigned HI_LSB       = FLD_W;
  localparam int unsigned OUT_BYP_BIT  = 6;
  localparam int unsigned OUT_HALF_BIT = 7;
  localparam int unsigned IN_BYP_BIT   = 2 * FLD_W;
  localparam int unsigned IN_HALF_BIT  = 2 * FLD_W + 1;

  typedef struct packed {
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;
    logic             half;
    logic             byp;
  } shape_t;

  // A zero field stands for the largest count.
  function automatic logic [CNT_W-1:0] fld_len(input logic [FLD_W-1:0] f);
    return (f == '0) ? {1'b1, {FLD_W{1'b0}}} : {1'b0, f};
  endfunction

endpackage

// File: rtl/hlcd_cfg_decode.sv
module hlcd_cfg_decode
  import hlcd_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter bit          IN_LAYOUT = 1'b0
) (
  input  logic [WORD_W-1:0] w1_i,
  input  logic [WORD_W-1:0] w2_i,
  output shape_t            shape_o
);

  generate
    if (IN_LAYOUT) begin : g_in_layout
      logic [CNT_W-1:0] hi_len;
      logic [CNT_W-1:0] lo_len;
      logic             unused_bits;
      assign hi_len      = fld_len(w1_i[HI_LSB +: FLD_W]);
      assign lo_len      = fld_len(w1_i[LO_LSB +: FLD_W]);
      assign shape_o     = {hi_len, lo_len, w1_i[IN_HALF_BIT], w1_i[IN_BYP_BIT]};
      assign unused_bits = ^{w1_i[WORD_W-1:IN_HALF_BIT+1], w2_i};
    end else begin : g_out_layout
      logic [CNT_W-1:0] hi_len;
      logic [CNT_W-1:0] lo_len;
      logic             unused_bits;
      assign hi_len      = fld_len(w1_i[HI_LSB +: FLD_W]);
      assign lo_len      = fld_len(w1_i[LO_LSB +: FLD_W]);
      assign shape_o     = {hi_len, lo_len, w2_i[OUT_HALF_BIT], w2_i[OUT_BYP_BIT]};
      assign unused_bits = ^{w1_i[WORD_W-1:HI_LSB+FLD_W],
                             w2_i[WORD_W-1:OUT_HALF_BIT+1],
                             w2_i[OUT_BYP_BIT-1:0]};
    end
  endgenerate

endmodule

// File: rtl/hlcd_ratio_pack.sv
module hlcd_ratio_pack
  import hlcd_pkg::*;
#(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned WORD_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [WORD_W-1:0]  out_w1_o,
  output logic [WORD_W-1:0]  out_w2_o,
  output logic [WORD_W-1:0]  in_w_o
);

  localparam int unsigned MAX_RATIO = 1 << (FLD_W + 1);

  logic [RATIO_W-1:0] n_clamp;
  logic [RATIO_W-1:0] hi_n;
  logic [RATIO_W-1:0] lo_n;
  logic [FLD_W-1:0]   hi_f;
  logic [FLD_W-1:0]   lo_f;
  logic               byp_f;
  logic               half_f;
  logic [WORD_W-1:0]  w1_d;
  logic [WORD_W-1:0]  w2_d;
  logic [WORD_W-1:0]  in_d;
  logic               unused_top;

  always_comb begin
    if (ratio_i == '0)                              n_clamp = RATIO_W'(1);
    else if (ratio_i > RATIO_W'(MAX_RATIO))         n_clamp = RATIO_W'(MAX_RATIO);
    else                                            n_clamp = ratio_i;
  end

  assign hi_n   = n_clamp >> 1;
  assign lo_n   = n_clamp - hi_n;
  assign byp_f  = (n_clamp == RATIO_W'(1));
  assign half_f = n_clamp[0] & ~byp_f;
  assign hi_f   = byp_f ? FLD_W'(1) : hi_n[FLD_W-1:0];
  assign lo_f   = lo_n[FLD_W-1:0];
  assign unused_top = ^{hi_n[RATIO_W-1:FLD_W], lo_n[RATIO_W-1:FLD_W]};

  always_comb begin
    w1_d = '0;
    w1_d[LO_LSB +: FLD_W] = lo_f;
    w1_d[HI_LSB +: FLD_W] = hi_f;
    w2_d = '0;
    w2_d[OUT_BYP_BIT]  = byp_f;
    w2_d[OUT_HALF_BIT] = half_f;
    in_d = w1_d;
    in_d[IN_BYP_BIT]   = byp_f;
    in_d[IN_HALF_BIT]  = half_f;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_w1_o <= '0;
      out_w2_o <= '0;
      in_w_o   <= '0;
    end else begin
      out_w1_o <= w1_d;
      out_w2_o <= w2_d;
      in_w_o   <= in_d;
    end
  end

  AST_PACK_SUM: assert property (@(posedge clk_i) disable iff (rst_i)
    (ratio_i >= RATIO_W'(2)) && (ratio_i <= RATIO_W'(MAX_RATIO)) |=>
      (RATIO_W'(fld_len(out_w1_o[HI_LSB +: FLD_W])) +
       RATIO_W'(fld_len(out_w1_o[LO_LSB +: FLD_W]))) == $past(ratio_i)); // R9

  AST_PACK_BYP: assert property (@(posedge clk_i) disable iff (rst_i)
    (ratio_i <= RATIO_W'(1)) |=> out_w2_o[OUT_BYP_BIT] && in_w_o[IN_BYP_BIT]); // R10

endmodule

// File: rtl/hlcd_wave_gen.sv
module hlcd_wave_gen
  import hlcd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  shape_t shape_i,
  output logic   clk_o
);

  localparam int unsigned POS_W = PER_W - 1;

  shape_t           act_q;
  logic             run_q;
  logic             lvl_q;
  logic             ext_q;
  logic [POS_W-1:0] pos_q;
  logic [PER_W-1:0] per_act;
  logic             at_end;
  logic             start;

  assign per_act = act_q.byp ? PER_W'(1)
                             : (PER_W'(act_q.hi_len) + PER_W'(act_q.lo_len));
  assign at_end  = (PER_W'(pos_q) == (per_act - PER_W'(1)));
  assign start   = !run_q || at_end;

  // Phase counter and main level, rising edge.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q <= '0;
      run_q <= 1'b0;
      lvl_q <= 1'b0;
      pos_q <= '0;
    end else if (start) begin
      act_q <= shape_i;
      run_q <= 1'b1;
      lvl_q <= 1'b1;
      pos_q <= '0;
    end else begin
      pos_q <= pos_q + POS_W'(1);
      lvl_q <= (PER_W'(pos_q) + PER_W'(1)) < PER_W'(act_q.hi_len);
    end
  end

  // Half-cycle stretch, falling edge.
  always_ff @(negedge clk_i) begin
    if (rst_i) ext_q <= 1'b0;
    else       ext_q <= lvl_q & act_q.half & ~act_q.byp;
  end

  assign clk_o = act_q.byp ? clk_i : (lvl_q | ext_q);

  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q |-> (PER_W'(pos_q) < per_act)); // R1

  AST_LOW_AT_END: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q && !act_q.byp && at_end |-> !lvl_q); // R1

  AST_FIRST_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_q |=> lvl_q && run_q); // R7

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q && !at_end |=> $stable(act_q)); // R6

  AST_EXT_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
    ext_q |-> act_q.half && !act_q.byp); // R3

endmodule

// File: rtl/hl_clk_divider.sv
module hl_clk_divider
  import hlcd_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned RATIO_W   = 8,
  parameter bit          IN_LAYOUT = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [WORD_W-1:0]  cfg_w1_i,
  input  logic [WORD_W-1:0]  cfg_w2_i,
  output logic               clk_o,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [WORD_W-1:0]  pk_w1_o,
  output logic [WORD_W-1:0]  pk_w2_o,
  output logic [WORD_W-1:0]  pk_in_o
);

  shape_t shape;

  hlcd_cfg_decode #(
    .WORD_W    (WORD_W),
    .IN_LAYOUT (IN_LAYOUT)
  ) u_decode (
    .w1_i    (cfg_w1_i),
    .w2_i    (cfg_w2_i),
    .shape_o (shape)
  );

  hlcd_wave_gen u_wave (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .shape_i (shape),
    .clk_o   (clk_o)
  );

  hlcd_ratio_pack #(
    .RATIO_W (RATIO_W),
    .WORD_W  (WORD_W)
  ) u_pack (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ratio_i  (ratio_i),
    .out_w1_o (pk_w1_o),
    .out_w2_o (pk_w2_o),
    .in_w_o   (pk_in_o)
  );

endmodule

// File: tb/hl_clk_divider_tb_top.sv
module hl_clk_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] w1 = '0;
  logic [15:0] w2 = '0;
  logic [7:0]  ratio = '0;
  logic        clk_o;
  logic [15:0] pk_w1;
  logic [15:0] pk_w2;
  logic [15:0] pk_in;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hl_clk_divider dut_i (
    .clk_i    (clk),
    .rst_i    (rst),
    .cfg_w1_i (w1),
    .cfg_w2_i (w2),
    .clk_o    (clk_o),
    .ratio_i  (ratio),
    .pk_w1_o  (pk_w1),
    .pk_w2_o  (pk_w2),
    .pk_in_o  (pk_in)
  );

  // Reference model state, built from the requirements.
  bit m_first = 1'b1;
  int m_pos = 0;
  int m_h = 1;
  int m_l = 1;
  bit m_e = 1'b0;
  bit m_b = 1'b0;

  function automatic int flen(input int f);
    return (f == 0) ? 64 : f;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // R2 layout: low 5:0, high 11:6; bypass bit 6, half bit 7.
  task automatic set_cfg(input int h, input int l, input bit e, input bit b);
    w1 = 16'((h % 64) << 6) | 16'(l % 64);
    w2 = (16'(e) << 7) | (16'(b) << 6);
  endtask

  // One input cycle: update the model at the rising edge, then check both halves.
  task automatic step(input string req);
    int per;
    bit e0;
    bit e1;
    @(posedge clk);
    per = m_b ? 1 : m_h + m_l;
    if (m_first || m_pos == per - 1) begin
      m_first = 1'b0;
      m_pos = 0;
      m_h = flen(int'(w1[11:6]));
      m_l = flen(int'(w1[5:0]));
      m_e = w2[7];
      m_b = w2[6];
    end else begin
      m_pos++;
    end
    if (m_b) begin
      e0 = 1'b1;
      e1 = 1'b0;
    end else begin
      e0 = (m_pos < m_h) || (m_e && m_pos == m_h);
      e1 = (m_pos < m_h);
    end
    #2 chk(req, clk_o, e0, "first half");
    #5 chk(req, clk_o, e1, "second half");
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #2;
      if (i == 2) chk("R7", clk_o, 1'b0, "reset first half");
      #5;
      if (i == 2) chk("R7", clk_o, 1'b0, "reset second half");
      #2;
    end
    rst = 1'b0;
    m_first = 1'b1;
  endtask

  task automatic t_reset();
    set_cfg(2, 2, 1'b0, 1'b0);
    do_reset();
    step("R7");
  endtask

  task automatic t_even();
    set_cfg(2, 2, 1'b0, 1'b0);
    do_reset();
    for (int i = 0; i < 12; i++) step("R1");
  endtask

  task automatic t_odd_half();
    set_cfg(3, 4, 1'b1, 1'b0);
    do_reset();
    for (int i = 0; i < 21; i++) step("R3");
  endtask

  task automatic t_uneven();
    set_cfg(1, 5, 1'b0, 1'b0);
    w1[15:12] = 4'hF;
    w2[5:0] = 6'h3F;
    w2[15:8] = 8'hFF;
    do_reset();
    for (int i = 0; i < 18; i++) step("R2");
  endtask

  task automatic t_zero_fields();
    set_cfg(0, 0, 1'b0, 1'b0);
    do_reset();
    for (int i = 0; i < 256; i++) step("R4");
    set_cfg(0, 3, 1'b1, 1'b0);
    do_reset();
    for (int i = 0; i < 67; i++) step("R4");
  endtask

  task automatic t_bypass();
    set_cfg(1, 1, 1'b0, 1'b1);
    do_reset();
    for (int i = 0; i < 6; i++) step("R5");
    set_cfg(1, 2, 1'b1, 1'b0);
    for (int i = 0; i < 9; i++) step("R5");
  endtask

  task automatic t_mid_change();
    set_cfg(3, 3, 1'b0, 1'b0);
    do_reset();
    for (int i = 0; i < 2; i++) step("R6");
    set_cfg(5, 1, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) step("R6");
    set_cfg(2, 3, 1'b0, 1'b0);
    step("R6");
    set_cfg(4, 4, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step("R6");
  endtask

  task automatic t_restart();
    set_cfg(2, 3, 1'b1, 1'b0);
    do_reset();
    for (int i = 0; i < 7; i++) step("R7");
    do_reset();
    for (int i = 0; i < 10; i++) step("R7");
  endtask

  task automatic t_pack();
    int nn;
    int h;
    int l;
    int e;
    int b;
    logic [15:0] x1;
    logic [15:0] x2;
    logic [15:0] xin;
    for (int n = 0; n <= 200; n++) begin
      ratio = 8'(n);
      nn = (n == 0) ? 1 : ((n > 128) ? 128 : n);
      if (nn == 1) begin
        h = 1; l = 1; e = 0; b = 1;
      end else begin
        h = nn / 2; l = nn - h; e = nn % 2; b = 0;
      end
      x1  = 16'((h % 64) << 6) | 16'(l % 64);
      x2  = 16'(e << 7) | 16'(b << 6);
      xin = x1 | 16'(b << 12) | 16'(e << 13);
      @(posedge clk);
      #2;
      if (n == 0 || n > 128) begin
        chk16("R10", pk_w1, x1, "clamped count word");
        chk16("R10", pk_w2, x2, "clamped flag word");
      end else if (n == 1) begin
        chk16("R9", pk_w1, x1, "bypass count word");
        chk16("R9", pk_w2, x2, "bypass flag word");
      end else begin
        chk16("R9", pk_w1, x1, "count word");
        chk16("R9", pk_w2, x2, "flag word");
        chk16("R9", 16'(flen(int'(pk_w1[11:6])) + flen(int'(pk_w1[5:0]))), 16'(nn), "read-back sum");
      end
      chk16("R8", pk_in, xin, "single-word layout");
      #7;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    t_reset();
    t_even();
    t_odd_half();
    t_uneven();
    t_zero_fields();
    t_bypass();
    t_mid_change();
    t_restart();
    t_pack();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule